// File: doc/BRIEF.md
# FIFO Read-Port Output Stage with Chip Select

This block is the last stage of a first-word-fall-through FIFO read port. It sits between the storage array and the shared read data bus. It holds one word in an output register and asks storage for the next word through a pop strobe. It also decides, on read-clock edges, whether the tri-state data bus may be driven.

Chip select acts only on the bus drive and on read qualification. It never stops a word from falling into an empty output register. A word that arrives while the port is deselected therefore waits in the register until the bus is enabled and a read consumes it. Output enable is an asynchronous override that can always release the bus. During reset it is the only control that decides whether the bus is driven.

Top module: `fifo_rd_output`

## Requirements
- R1: While rstN is low, popStrobe is 0, qData is 0, and busDrive equals the inverse of oeN, whatever the level of csN.
- R2: After rstN rises, busDrive keeps following only the inverse of oeN until the first rising clock edge. That edge samples csN.
- R3: A change on csN alters busDrive only at the next rising clock edge. Low csN selects drive and high csN selects high impedance.
- R4: busDrive is the registered chip-select state ANDed with the inverse of oeN. A high oeN releases the bus at once, without waiting for a clock edge.
- R5: When the output register holds no valid word and empty is 0, popStrobe is 1 and the next edge loads storeData into qData, at any level of csN and renN.
- R6: A qualified read (csN low, renN low, valid word held) at a rising edge with empty 0 asserts popStrobe and loads the next word. With empty 1, it marks the register invalid and leaves qData unchanged.
- R7: A read attempted while the register holds no valid word and empty is 1 is ignored: popStrobe stays 0 and qData is unchanged.
- R8: Without a qualified read, a valid word stays in qData and popStrobe stays 0, including while csN is high and renN is low.
- R9: Protocol rule: renN must be high at the first rising edge that samples csN low after it was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| rstN | input | 1 | Asynchronous active-low reset (master or partial) |
| csN | input | 1 | Active-low read chip select |
| renN | input | 1 | Active-low read enable |
| oeN | input | 1 | Active-low asynchronous output enable |
| empty | input | 1 | Storage holds no word |
| storeData | input | DATA_W | Next word offered by storage |
| qData | output | DATA_W | Output register contents |
| busDrive | output | 1 | Drive enable for the tri-state read bus |
| popStrobe | output | 1 | Storage advances to its next word at this edge |

## Verification
The bench builds the block with DATA_W at 16, so each stored word carries a distinct tag and a lost, repeated or early-loaded word appears directly on qData. At this width the bench can cover a fall-through while the port is deselected, a read that drains the last word, a read attempt on an invalid register, and an asynchronous reset in the middle of a run. A streaming burst then confirms that each qualified edge moves exactly one new word into the register.

// File: rtl/fifo_rd_output_pkg.sv
package fifo_rd_output_pkg;

  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic load;   // capture the storage word into the output register
    logic drop;   // register word consumed with nothing to replace it
  } outStrobe_t;

endpackage

// File: rtl/fifo_rd_output_ctrl.sv
module fifo_rd_output_ctrl
  import fifo_rd_output_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       renN,
  input  logic       empty,
  output outStrobe_t strobe,
  output logic       popStrobe,
  output logic       csEnable
);

  logic qValid;
  logic readQual;
  logic fill;

  // A read counts only with the port selected, enabled and a word held
  assign readQual = ~csN & ~renN & qValid;
  // Fall-through ignores chip select: refill whenever the register is free
  assign fill     = rstN & ~empty & (~qValid | readQual);

  assign strobe.load = fill;
  assign strobe.drop = readQual & empty;
  assign popStrobe   = fill;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qValid <= 1'b0;
    end else if (fill) begin
      qValid <= 1'b1;
    end else if (strobe.drop) begin
      qValid <= 1'b0;
    end
  end

  // Chip-select state: held enabled through reset so that output enable
  // alone rules the bus until the first edge after release
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csEnable <= 1'b1;
    end else begin
      csEnable <= ~csN;
    end
  end

endmodule

// File: rtl/fifo_rd_output_dp.sv
module fifo_rd_output_dp
  import fifo_rd_output_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  outStrobe_t        strobe,
  input  logic [DATA_W-1:0] storeData,
  output logic [DATA_W-1:0] qData
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qData <= '0;
    end else if (strobe.load) begin
      qData <= storeData;
    end
  end

endmodule

// File: rtl/fifo_rd_output.sv
module fifo_rd_output
  import fifo_rd_output_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              renN,
  input  logic              oeN,
  input  logic              empty,
  input  logic [DATA_W-1:0] storeData,
  output logic [DATA_W-1:0] qData,
  output logic              busDrive,
  output logic              popStrobe
);

  outStrobe_t strobe;
  logic       csEnable;

  fifo_rd_output_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .csN       (csN),
    .renN      (renN),
    .empty     (empty),
    .strobe    (strobe),
    .popStrobe (popStrobe),
    .csEnable  (csEnable)
  );

  fifo_rd_output_dp #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .storeData (storeData),
    .qData     (qData)
  );

  // Output enable acts without a clock on top of the registered select
  assign busDrive = csEnable & ~oeN;

endmodule

// File: rtl/fifo_rd_output_chk.sv
module fifo_rd_output_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic              renN,
  input logic              oeN,
  input logic              empty,
  input logic [DATA_W-1:0] storeData,
  input logic [DATA_W-1:0] qData,
  input logic              busDrive,
  input logic              popStrobe
);

  logic lastCsN;
  logic csSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastCsN <= 1'b1;
      csSeen  <= 1'b1;
    end else begin
      lastCsN <= csN;
      csSeen  <= ~csN;
    end
  end

  assert_no_pop_in_reset_R1: assert property (@(posedge clk)
    !rstN |-> !popStrobe);

  assert_drive_follows_sampled_cs_R4: assert property (@(posedge clk) disable iff (!rstN)
    busDrive == (csSeen && !oeN));

  assert_load_takes_storage_word_R5: assert property (@(posedge clk) disable iff (!rstN)
    popStrobe |=> qData == $past(storeData));

  assert_no_pop_when_empty_R7: assert property (@(posedge clk) disable iff (!rstN)
    empty |-> !popStrobe);

  assert_word_held_without_pop_R8: assert property (@(posedge clk) disable iff (!rstN)
    !popStrobe |=> $stable(qData));

  assert_ren_idle_after_select_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && lastCsN) |-> renN);

endmodule

bind fifo_rd_output fifo_rd_output_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .csN       (csN),
  .renN      (renN),
  .oeN       (oeN),
  .empty     (empty),
  .storeData (storeData),
  .qData     (qData),
  .busDrive  (busDrive),
  .popStrobe (popStrobe)
);

// File: tb/fifo_rd_output_test.sv
`timescale 1ns/1ps
module fifo_rd_output_test;

  localparam int DATA_W = 16;
  localparam int NVEC   = 16;
  localparam int VEC_W  = 5 + DATA_W + 2 + DATA_W;

  logic              clk = 1'b0;
  logic              rstN, csN, renN, oeN, empty;
  logic [DATA_W-1:0] storeData;
  logic [DATA_W-1:0] qData;
  logic              busDrive, popStrobe;

  int  applied = 0;
  int  failed  = 0;
  bit  done    = 1'b0;
  logic prevCsN = 1'b1;

  always #2.5 clk = ~clk;

  fifo_rd_output #(.DATA_W(DATA_W)) uut (
    .clk(clk), .rstN(rstN), .csN(csN), .renN(renN), .oeN(oeN),
    .empty(empty), .storeData(storeData), .qData(qData),
    .busDrive(busDrive), .popStrobe(popStrobe)
  );

  // {rstN,csN,renN,oeN,empty}, storeData, {expPop,expDrive}, expQ
  localparam logic [VEC_W-1:0] VEC [NVEC] = '{
    {5'b01101, 16'h0000, 2'b01, 16'h0000},
    {5'b01110, 16'h1111, 2'b00, 16'h0000},
    {5'b11101, 16'h0000, 2'b01, 16'h0000},
    {5'b11100, 16'hA001, 2'b10, 16'h0000},
    {5'b11000, 16'hA002, 2'b00, 16'hA001},
    {5'b10100, 16'hA002, 2'b00, 16'hA001},
    {5'b10000, 16'hA002, 2'b11, 16'hA001},
    {5'b10011, 16'h0000, 2'b00, 16'hA002},
    {5'b10001, 16'h0000, 2'b01, 16'hA002},
    {5'b10000, 16'hB001, 2'b11, 16'hA002},
    {5'b10100, 16'hB002, 2'b01, 16'hB001},
    {5'b11100, 16'hB002, 2'b01, 16'hB001},
    {5'b11100, 16'hB002, 2'b00, 16'hB001},
    {5'b00000, 16'hC001, 2'b01, 16'h0000},
    {5'b11100, 16'hC001, 2'b11, 16'h0000},
    {5'b11100, 16'hC002, 2'b00, 16'hC001}
  };

  function automatic string reqOf(int idx);
    case (idx)
      0, 1, 13:  return "R1";
      2, 14:     return "R2";
      5, 11, 12: return "R3";
      7:         return "R4";
      3, 9, 15:  return "R5";
      6:         return "R6";
      8:         return "R7";
      default:   return "R8";
    endcase
  endfunction

  // Drive after a falling edge; flags any breach of the select rule (R9)
  task automatic drive(input logic r, input logic c, input logic re,
                       input logic o, input logic e, input logic [DATA_W-1:0] d);
    @(negedge clk);
    rstN = r; csN = c; renN = re; oeN = o; empty = e; storeData = d;
    if (r && !c && prevCsN) begin
      applied++;
      if (!re) begin
        failed++;
        $display("FAIL R9: renN actual %0b expected 1 at first selected edge", re);
      end
    end
    prevCsN = r ? c : 1'b1;
  endtask

  task automatic expect_out(input string req, input logic ePop, input logic eDrv,
                            input logic [DATA_W-1:0] eQ);
    #1;
    applied++;
    if (popStrobe !== ePop || busDrive !== eDrv || qData !== eQ) begin
      failed++;
      $display("FAIL %s: pop/drive/q actual %0b/%0b/%h expected %0b/%0b/%h",
               req, popStrobe, busDrive, qData, ePop, eDrv, eQ);
    end
  endtask

  initial begin
    rstN = 1'b0; csN = 1'b1; renN = 1'b1; oeN = 1'b0; empty = 1'b1; storeData = '0;

    for (int i = 0; i < NVEC; i++) begin
      logic [VEC_W-1:0] v;
      v = VEC[i];
      drive(v[VEC_W-1], v[VEC_W-2], v[VEC_W-3], v[VEC_W-4], v[VEC_W-5],
            v[2*DATA_W+1:DATA_W+2]);
      expect_out(reqOf(i), v[DATA_W+1], v[DATA_W], v[DATA_W-1:0]);
    end

    // R3 directed: select then a burst of qualified reads, R6 stream
    drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 16'hD000);
    expect_out("R3", 1'b0, 1'b0, 16'hC001);
    for (int k = 0; k < 8; k++) begin
      drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'hD000 + 16'(k));
      expect_out("R6", 1'b1, 1'b1, (k == 0) ? 16'hC001 : 16'hD000 + 16'(k - 1));
    end
    // R6 drain: last word read with storage empty, then no refill
    drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 16'h0000);
    expect_out("R6", 1'b0, 1'b1, 16'hD007);
    drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0000);
    expect_out("R7", 1'b0, 1'b1, 16'hD007);
    // R5 refill after drain while deselected
    drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 16'hE001);
    expect_out("R5", 1'b1, 1'b1, 16'hD007);
    drive(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 16'hE002);
    expect_out("R5", 1'b0, 1'b0, 16'hE001);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", applied, failed);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      applied++;
      failed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", applied, failed);
      $finish;
    end
  end

endmodule